// File: doc/BRIEF.md
# Path Tandem Connection Overhead Byte Processor

This block handles the path overhead byte that carries tandem connection maintenance data, one byte per frame, in both directions. On the transmit side it assembles the outgoing byte once per frame from three sources: a default value written by the processor, a byte taken from the serial insert bus, and the 4-bit parity error count (or signal fail code) from the local receiver. The upper nibble (bits 1–4, bit 1 being the most significant bit) has a two-bit source select. Setting both selects forces the nibble to all ones. The lower nibble (bits 5–8) has a one-bit select between the default value and the insert bus.

On the receive side the block captures the incoming byte on every frame strobe into a register the processor can read. It also examines the error-count nibble. An all-ones nibble is recorded as incoming signal fail. Any other nonzero value is recorded as a tandem error count. Both results are held in sticky status flags until the processor clears them. A mask input gates the interrupt output and does not affect the flags. Frame alignment and the parity calculation are done elsewhere; this block only receives a one-cycle frame strobe and the 4-bit count.

Top module: `tcm_byte_proc`

## Requirements
- R1: After reset, tx_byte_o, rx_latch_o, isf_o, tec_o and irq_o are all zero.
- R2: When all three transmit selects are low at a frame strobe, tx_byte_o equals cfg_default_i from the cycle after the strobe.
- R3: When sel_cnt_i is high and sel_ins_cnt_i is low at a frame strobe, tx_byte_o[7:4] equals rx_errcnt_i from the cycle after the strobe.
- R4: When sel_ins_cnt_i is high and sel_cnt_i is low at a frame strobe, tx_byte_o[7:4] equals ins_byte_i[7:4] from the cycle after the strobe.
- R5: When sel_cnt_i and sel_ins_cnt_i are both high at a frame strobe, tx_byte_o[7:4] is 4'b1111 from the cycle after the strobe.
- R6: At a frame strobe, tx_byte_o[3:0] takes ins_byte_i[3:0] when sel_ins_dch_i is high, and cfg_default_i[3:0] when it is low.
- R7: tx_byte_o changes only in the cycle after a frame strobe. Changes to its sources between strobes have no effect on it.
- R8: rx_latch_o takes rx_byte_i on every frame strobe and holds that value between strobes.
- R9: A frame strobe with rx_byte_i[7:4] == 4'b1111 sets isf_o and does not set tec_o. isf_o then stays set until it is cleared.
- R10: A frame strobe with rx_byte_i[7:4] nonzero and not 4'b1111 sets tec_o. tec_o then stays set until it is cleared. A value of zero sets neither flag.
- R11: clr_i clears both status flags in the next cycle. If a flag is being set in the same cycle that clr_i is high, the flag ends up set.
- R12: irq_o is high exactly when (isf_o or tec_o) is high and mask_i is low. mask_i has no effect on the status flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_i | input | 1 | One-cycle frame strobe; marks the byte slot |
| sel_cnt_i | input | 1 | Upper transmit nibble from the local error count |
| sel_ins_cnt_i | input | 1 | Upper transmit nibble from the insert bus |
| sel_ins_dch_i | input | 1 | Lower transmit nibble from the insert bus |
| cfg_default_i | input | 8 | Processor default transmit byte |
| ins_byte_i | input | 8 | Byte taken from the serial insert bus |
| rx_errcnt_i | input | 4 | Local received parity error count or signal fail code |
| tx_byte_o | output | 8 | Outgoing overhead byte |
| rx_byte_i | input | 8 | Incoming overhead byte, valid with frame_i |
| clr_i | input | 1 | Clears both status flags |
| mask_i | input | 1 | Interrupt mask |
| rx_latch_o | output | 8 | Latched received byte |
| isf_o | output | 1 | Sticky incoming signal fail flag |
| tec_o | output | 1 | Sticky tandem error count flag |
| irq_o | output | 1 | Maskable interrupt |

## Verification
The hardest case to reach from the ports is a clear and a new detection arriving in the same cycle. To check it, the stimulus first sets a flag, then drives clr_i high in the same cycle as a strobe carrying an error count, and confirms that the flag remains set. A second hard case is checking that a masked interrupt still records status. For this the bench raises mask_i before a signal fail frame, checks that isf_o is set while irq_o stays low, and then releases the mask to see the interrupt appear. The selector cases, including the forced all-ones nibble, are covered by a table in which the default, insert and count values are all different, so any crossed source shows up.

// File: rtl/tcm_pkg.sv
package tcm_pkg;

    localparam int TCM_BYTE_W = 8;

    typedef enum logic [1:0] {
        NIB_DEFAULT = 2'd0,
        NIB_COUNT   = 2'd1,
        NIB_INSERT  = 2'd2,
        NIB_ONES    = 2'd3
    } nib_src_e;

    function automatic nib_src_e upper_src(input logic use_cnt, input logic use_ins);
        nib_src_e s;
        case ({use_cnt, use_ins})
            2'b10:   s = NIB_COUNT;
            2'b01:   s = NIB_INSERT;
            2'b11:   s = NIB_ONES;
            default: s = NIB_DEFAULT;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/tcm_tx_mux.sv
module tcm_tx_mux #(
    parameter int BYTE_W = tcm_pkg::TCM_BYTE_W
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   frame_i,
    input  logic                   sel_cnt_i,
    input  logic                   sel_ins_cnt_i,
    input  logic                   sel_ins_dch_i,
    input  logic [BYTE_W-1:0]      cfg_default_i,
    input  logic [BYTE_W-1:0]      ins_byte_i,
    input  logic [BYTE_W/2-1:0]    rx_errcnt_i,
    output logic [BYTE_W-1:0]      tx_byte_o
);
    localparam int NIB_W = BYTE_W / 2;

    typedef struct packed {
        logic [NIB_W-1:0] hi;
        logic [NIB_W-1:0] lo;
    } tx_state_t;

    tx_state_t        st_d, st_q;
    tcm_pkg::nib_src_e src;

    always_comb begin
        src  = tcm_pkg::upper_src(sel_cnt_i, sel_ins_cnt_i);
        st_d = st_q;
        if (frame_i) begin
            case (src)
                tcm_pkg::NIB_COUNT:  st_d.hi = rx_errcnt_i;
                tcm_pkg::NIB_INSERT: st_d.hi = ins_byte_i[BYTE_W-1:NIB_W];
                tcm_pkg::NIB_ONES:   st_d.hi = '1;
                default:             st_d.hi = cfg_default_i[BYTE_W-1:NIB_W];
            endcase
            st_d.lo = sel_ins_dch_i ? ins_byte_i[NIB_W-1:0] : cfg_default_i[NIB_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign tx_byte_o = {st_q.hi, st_q.lo};
endmodule

// File: rtl/tcm_rx_mon.sv
module tcm_rx_mon #(
    parameter int BYTE_W = tcm_pkg::TCM_BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_i,
    input  logic [BYTE_W-1:0] rx_byte_i,
    input  logic              clr_i,
    output logic [BYTE_W-1:0] rx_latch_o,
    output logic              isf_o,
    output logic              tec_o
);
    localparam int NIB_W = BYTE_W / 2;

    typedef struct packed {
        logic [BYTE_W-1:0] latch;
        logic              isf;
        logic              tec;
    } rx_state_t;

    rx_state_t        st_d, st_q;
    logic [NIB_W-1:0] cnt_nib;
    logic             isf_hit;
    logic             tec_hit;

    always_comb begin
        cnt_nib = rx_byte_i[BYTE_W-1:NIB_W];
        isf_hit = frame_i && (cnt_nib == '1);
        tec_hit = frame_i && (cnt_nib != '0) && (cnt_nib != '1);

        st_d     = st_q;
        if (frame_i) st_d.latch = rx_byte_i;
        st_d.isf = isf_hit | (st_q.isf & ~clr_i);
        st_d.tec = tec_hit | (st_q.tec & ~clr_i);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rx_latch_o = st_q.latch;
    assign isf_o      = st_q.isf;
    assign tec_o      = st_q.tec;
endmodule

// File: rtl/tcm_byte_proc.sv
module tcm_byte_proc #(
    parameter int BYTE_W = tcm_pkg::TCM_BYTE_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                frame_i,
    input  logic                sel_cnt_i,
    input  logic                sel_ins_cnt_i,
    input  logic                sel_ins_dch_i,
    input  logic [BYTE_W-1:0]   cfg_default_i,
    input  logic [BYTE_W-1:0]   ins_byte_i,
    input  logic [BYTE_W/2-1:0] rx_errcnt_i,
    output logic [BYTE_W-1:0]   tx_byte_o,
    input  logic [BYTE_W-1:0]   rx_byte_i,
    input  logic                clr_i,
    input  logic                mask_i,
    output logic [BYTE_W-1:0]   rx_latch_o,
    output logic                isf_o,
    output logic                tec_o,
    output logic                irq_o
);
    tcm_tx_mux #(.BYTE_W(BYTE_W)) tx_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .frame_i       (frame_i),
        .sel_cnt_i     (sel_cnt_i),
        .sel_ins_cnt_i (sel_ins_cnt_i),
        .sel_ins_dch_i (sel_ins_dch_i),
        .cfg_default_i (cfg_default_i),
        .ins_byte_i    (ins_byte_i),
        .rx_errcnt_i   (rx_errcnt_i),
        .tx_byte_o     (tx_byte_o)
    );

    tcm_rx_mon #(.BYTE_W(BYTE_W)) rx_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_i    (frame_i),
        .rx_byte_i  (rx_byte_i),
        .clr_i      (clr_i),
        .rx_latch_o (rx_latch_o),
        .isf_o      (isf_o),
        .tec_o      (tec_o)
    );

    // Mask acts on the output only; flags keep recording underneath it.
    assign irq_o = (isf_o | tec_o) & ~mask_i;
endmodule

// File: rtl/tcm_byte_proc_chk.sv
module tcm_byte_proc_chk #(
    parameter int BYTE_W = tcm_pkg::TCM_BYTE_W
) (
    input logic                clk,
    input logic                rst_n,
    input logic                frame_i,
    input logic                sel_cnt_i,
    input logic                sel_ins_cnt_i,
    input logic                sel_ins_dch_i,
    input logic [BYTE_W-1:0]   cfg_default_i,
    input logic [BYTE_W-1:0]   ins_byte_i,
    input logic [BYTE_W/2-1:0] rx_errcnt_i,
    input logic [BYTE_W-1:0]   tx_byte_o,
    input logic [BYTE_W-1:0]   rx_byte_i,
    input logic                clr_i,
    input logic                mask_i,
    input logic [BYTE_W-1:0]   rx_latch_o,
    input logic                isf_o,
    input logic                tec_o,
    input logic                irq_o
);
    localparam int NIB_W = BYTE_W / 2;

    assert_default_R2: assert property (@(posedge clk) disable iff (!rst_n)
        frame_i && !sel_cnt_i && !sel_ins_cnt_i && !sel_ins_dch_i
        |=> tx_byte_o == $past(cfg_default_i));

    assert_count_nib_R3: assert property (@(posedge clk) disable iff (!rst_n)
        frame_i && sel_cnt_i && !sel_ins_cnt_i
        |=> tx_byte_o[BYTE_W-1:NIB_W] == $past(rx_errcnt_i));

    assert_insert_nib_R4: assert property (@(posedge clk) disable iff (!rst_n)
        frame_i && !sel_cnt_i && sel_ins_cnt_i
        |=> tx_byte_o[BYTE_W-1:NIB_W] == $past(ins_byte_i[BYTE_W-1:NIB_W]));

    assert_forced_ones_R5: assert property (@(posedge clk) disable iff (!rst_n)
        frame_i && sel_cnt_i && sel_ins_cnt_i
        |=> tx_byte_o[BYTE_W-1:NIB_W] == '1);

    assert_tx_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_i |=> $stable(tx_byte_o));

    assert_rx_latch_R8: assert property (@(posedge clk) disable iff (!rst_n)
        frame_i |=> rx_latch_o == $past(rx_byte_i));

    assert_isf_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
        frame_i && rx_byte_i[BYTE_W-1:NIB_W] == '1 |=> isf_o);

    assert_tec_set_R10: assert property (@(posedge clk) disable iff (!rst_n)
        frame_i && rx_byte_i[BYTE_W-1:NIB_W] != '1 && rx_byte_i[BYTE_W-1:NIB_W] != '0
        |=> tec_o);

    assert_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (isf_o || tec_o) && !clr_i && !frame_i |=> $stable({isf_o, tec_o}));

    assert_irq_gate_R12: assert property (@(posedge clk) disable iff (!rst_n)
        mask_i |-> !irq_o);
endmodule

bind tcm_byte_proc tcm_byte_proc_chk #(.BYTE_W(BYTE_W)) chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .frame_i       (frame_i),
    .sel_cnt_i     (sel_cnt_i),
    .sel_ins_cnt_i (sel_ins_cnt_i),
    .sel_ins_dch_i (sel_ins_dch_i),
    .cfg_default_i (cfg_default_i),
    .ins_byte_i    (ins_byte_i),
    .rx_errcnt_i   (rx_errcnt_i),
    .tx_byte_o     (tx_byte_o),
    .rx_byte_i     (rx_byte_i),
    .clr_i         (clr_i),
    .mask_i        (mask_i),
    .rx_latch_o    (rx_latch_o),
    .isf_o         (isf_o),
    .tec_o         (tec_o),
    .irq_o         (irq_o)
);

// File: tb/tcm_byte_proc_tb.sv
module tcm_byte_proc_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       frame_i = 1'b0;
    logic       sel_cnt_i = 1'b0, sel_ins_cnt_i = 1'b0, sel_ins_dch_i = 1'b0;
    logic [7:0] cfg_default_i = '0, ins_byte_i = '0, rx_byte_i = '0;
    logic [3:0] rx_errcnt_i = '0;
    logic       clr_i = 1'b0, mask_i = 1'b0;
    logic [7:0] tx_byte_o, rx_latch_o;
    logic       isf_o, tec_o, irq_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #10 clk = ~clk;

    tcm_byte_proc dut_i (
        .clk(clk), .rst_n(rst_n), .frame_i(frame_i),
        .sel_cnt_i(sel_cnt_i), .sel_ins_cnt_i(sel_ins_cnt_i), .sel_ins_dch_i(sel_ins_dch_i),
        .cfg_default_i(cfg_default_i), .ins_byte_i(ins_byte_i), .rx_errcnt_i(rx_errcnt_i),
        .tx_byte_o(tx_byte_o), .rx_byte_i(rx_byte_i), .clr_i(clr_i), .mask_i(mask_i),
        .rx_latch_o(rx_latch_o), .isf_o(isf_o), .tec_o(tec_o), .irq_o(irq_o)
    );

    // {sel_cnt, sel_ins_cnt, sel_ins_dch, default, insert, count, expected tx}
    localparam logic [30:0] VEC [8] = '{
        {3'b000, 8'hA5, 8'h3C, 4'h7, 8'hA5},  // R2
        {3'b100, 8'hA5, 8'h3C, 4'h7, 8'h75},  // R3
        {3'b010, 8'hA5, 8'h3C, 4'h7, 8'h35},  // R4
        {3'b110, 8'hA5, 8'h3C, 4'h7, 8'hF5},  // R5
        {3'b001, 8'hA5, 8'h3C, 4'h7, 8'hAC},  // R6
        {3'b101, 8'h12, 8'h9E, 4'h0, 8'h0E},  // R3 R6
        {3'b111, 8'h12, 8'h9E, 4'h3, 8'hFE},  // R5 R6
        {3'b011, 8'h12, 8'h9E, 4'hF, 8'h9E}   // R4 R6
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Strobe one frame: drive on a falling edge, sample on the following falling edge.
    task automatic strobe();
        frame_i = 1'b1;
        @(negedge clk);
        frame_i = 1'b0;
        clr_i   = 1'b0;
    endtask

    initial begin
        #(20 * 5000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 tx",    tx_byte_o,  8'h00);
        check("R1 latch", rx_latch_o, 8'h00);
        check("R1 isf",   {7'b0, isf_o}, 8'h00);
        check("R1 tec",   {7'b0, tec_o}, 8'h00);
        check("R1 irq",   {7'b0, irq_o}, 8'h00);

        foreach (VEC[i]) begin
            {sel_cnt_i, sel_ins_cnt_i, sel_ins_dch_i} = VEC[i][30:28];
            cfg_default_i = VEC[i][27:20];
            ins_byte_i    = VEC[i][19:12];
            rx_errcnt_i   = VEC[i][11:8];
            strobe();
            check($sformatf("R2-R6 vector %0d", i), tx_byte_o, VEC[i][7:0]);
        end

        // R7: sources move without a strobe; output holds
        sel_cnt_i = 1'b0; sel_ins_cnt_i = 1'b0; sel_ins_dch_i = 1'b0;
        cfg_default_i = 8'h55; ins_byte_i = 8'h00;
        repeat (3) @(negedge clk);
        check("R7 hold", tx_byte_o, 8'h9E);
        strobe();
        check("R7 update", tx_byte_o, 8'h55);

        // R8: latch each frame, hold between
        rx_byte_i = 8'h0B;
        strobe();
        check("R8 latch", rx_latch_o, 8'h0B);
        check("R10 zero nibble no tec", {6'b0, isf_o, tec_o}, 8'h00);
        rx_byte_i = 8'hC4;
        repeat (2) @(negedge clk);
        check("R8 hold", rx_latch_o, 8'h0B);

        // R9 + R12: signal fail with mask high
        mask_i = 1'b1;
        rx_byte_i = 8'hF3;
        strobe();
        check("R9 isf set", {7'b0, isf_o}, 8'h01);
        check("R9 no tec",  {7'b0, tec_o}, 8'h00);
        check("R12 masked irq", {7'b0, irq_o}, 8'h00);
        rx_byte_i = 8'h00;
        strobe();
        check("R9 sticky", {7'b0, isf_o}, 8'h01);
        mask_i = 1'b0;
        #1;
        check("R12 unmasked irq", {7'b0, irq_o}, 8'h01);

        // R11: clear
        @(negedge clk);
        clr_i = 1'b1;
        @(negedge clk);
        clr_i = 1'b0;
        check("R11 clear", {6'b0, isf_o, tec_o}, 8'h00);
        check("R11 irq drop", {7'b0, irq_o}, 8'h00);

        // R10: tandem error count
        rx_byte_i = 8'h2A;
        strobe();
        check("R10 tec set", {6'b0, isf_o, tec_o}, 8'h01);
        check("R12 tec irq", {7'b0, irq_o}, 8'h01);

        // R11: clear in the same cycle as a new detection
        clr_i = 1'b1;
        rx_byte_i = 8'h50;
        strobe();
        check("R11 set wins", {6'b0, isf_o, tec_o}, 8'h01);
        clr_i = 1'b1;
        @(negedge clk);
        clr_i = 1'b0;
        check("R11 clear after", {6'b0, isf_o, tec_o}, 8'h00);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule